// File: doc/BRIEF.md
# Posted Write Buffer for a Bus Controller

This block sits between a bus master (a processor or a DMA engine) and two target ports: a slow external memory port and a fast internal peripheral port. A write aimed at external memory is stored in a single-entry buffer and acknowledged at once. The master is then free to go on while the buffer drains the write to external memory in the background.

Accesses to the peripheral port may start and finish while the buffered write is still in flight. External reads are held behind the buffered write. A read from the address just written therefore returns only after that write has landed, which gives software a dummy-read way to confirm completion. A second external write that finds the buffer occupied stalls until the buffer is free. The buffer treats every master the same way, so a DMA transfer that reads from a peripheral can start its next read while its last external write is still draining.

Top module: `posted_wbuf`

## Requirements
- R1: After a synchronous reset, `m_ack`, `wb_busy`, `ext_req` and `per_req` are all low.
- R2: An external write that finds the buffer empty is acknowledged in the cycle after it is sampled, and `wb_busy` rises at the same edge. The buffer later issues one external write with the captured address, data and byte enables, where byte enable bit i covers data bits 8i+7..8i.
- R3: `wb_busy` stays high from capture until the external port acknowledges the buffered write, and falls one cycle after that acknowledge.
- R4: A write that arrives while the buffer is occupied is not acknowledged until the buffered write has completed at the external port. It is then captured as the new buffer content.
- R5: An access whose address bits [31:28] equal 4'hF goes to the peripheral port and completes while a buffered external write is still pending. Its acknowledge comes one cycle after `per_ack`.
- R6: No external read is issued while `wb_busy` is high. A read of an address just written returns the written data.
- R7: A read returns its data on `m_rdata` in the same cycle as `m_ack`, and never before the target has acknowledged the read.
- R8: `m_ack` is a one-cycle pulse. A request still held during its acknowledge cycle is not accepted a second time.
- R9: Peripheral accesses never appear on the external port, and external accesses never appear on the peripheral port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master request, held until `m_ack` |
| m_we | input | 1 | 1 = write, 0 = read |
| m_addr | input | AW | Byte address |
| m_wdata | input | DW | Write data |
| m_be | input | DW/8 | Byte enables |
| m_ack | output | 1 | One-cycle completion pulse |
| m_rdata | output | DW | Read data, valid with `m_ack` |
| wb_busy | output | 1 | Buffer holds a write not yet completed |
| ext_req | output | 1 | External request, held until `ext_ack` |
| ext_we | output | 1 | External write strobe |
| ext_addr | output | AW | External address |
| ext_wdata | output | DW | External write data |
| ext_be | output | DW/8 | External byte enables |
| ext_ack | input | 1 | External completion pulse |
| ext_rdata | input | DW | External read data |
| per_req | output | 1 | Peripheral request, held until `per_ack` |
| per_we | output | 1 | Peripheral write strobe |
| per_addr | output | AW | Peripheral address |
| per_wdata | output | DW | Peripheral write data |
| per_be | output | DW/8 | Peripheral byte enables |
| per_ack | input | 1 | Peripheral completion pulse |
| per_rdata | input | DW | Peripheral read data |

## Verification
A posted write is due one cycle after the request is sampled, so the bench samples `m_ack` and `wb_busy` at the first falling edge after that rising edge. Peripheral and read acknowledges depend on the target models' latency. For these the bench counts the falling edges until `m_ack`, and compares that count and the target models' completion counters against the order the requirements demand, not against a fixed cycle number. `wb_busy` is followed one falling edge at a time until it drops, and is compared with the moment the external model finished the write.

// File: rtl/posted_wbuf_pkg.sv
package posted_wbuf_pkg;
  typedef enum logic [1:0] {
    FE_IDLE = 2'd0,
    FE_PER  = 2'd1,
    FE_RD   = 2'd2
  } fe_state_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WR   = 2'd1,
    SQ_RD   = 2'd2
  } sq_state_t;
endpackage

// File: rtl/posted_wbuf_entry.sv
module posted_wbuf_entry #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  input  logic [BW-1:0] cap_be,
  input  logic          clr,
  output logic          valid,
  output logic [AW-1:0] buf_addr,
  output logic [DW-1:0] buf_data,
  output logic [BW-1:0] buf_be
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (cap) begin
      valid <= 1'b1;
    end else if (clr) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) buf_addr <= cap_addr;
  end

  for (genvar g = 0; g < BW; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (cap) begin
        buf_data[g*8 +: 8] <= cap_data[g*8 +: 8];
        buf_be[g]          <= cap_be[g];
      end
    end
  end

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
    valid && !clr |=> valid)
    else $error("buffer entry lost before drain");

  p_no_overwrite_r4: assert property (@(posedge clk) disable iff (rst)
    valid && !clr |-> !cap)
    else $error("capture into occupied buffer");
endmodule

// File: rtl/posted_wbuf_seq.sv
module posted_wbuf_seq
  import posted_wbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          buf_valid,
  input  logic [AW-1:0] buf_addr,
  input  logic [DW-1:0] buf_data,
  input  logic [BW-1:0] buf_be,
  output logic          wr_done,
  input  logic          rd_cmd,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          seq_idle,
  output logic          ext_req,
  output logic          ext_we,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  output logic [BW-1:0] ext_be,
  input  logic          ext_ack,
  input  logic [DW-1:0] ext_rdata
);
  sq_state_t st;

  assign seq_idle = (st == SQ_IDLE);
  assign wr_done  = (st == SQ_WR) && ext_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      ext_req <= 1'b0;
      ext_we  <= 1'b0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (buf_valid) begin
            ext_req   <= 1'b1;
            ext_we    <= 1'b1;
            ext_addr  <= buf_addr;
            ext_wdata <= buf_data;
            ext_be    <= buf_be;
            st        <= SQ_WR;
          end else if (rd_cmd) begin
            ext_req  <= 1'b1;
            ext_we   <= 1'b0;
            ext_addr <= rd_addr;
            ext_be   <= '1;
            st       <= SQ_RD;
          end
        end
        SQ_WR: begin
          if (ext_ack) begin
            ext_req <= 1'b0;
            ext_we  <= 1'b0;
            st      <= SQ_IDLE;
          end
        end
        SQ_RD: begin
          if (ext_ack) begin
            ext_req <= 1'b0;
            rd_done <= 1'b1;
            rd_data <= ext_rdata;
            st      <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  p_ext_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ext_req && !ext_ack |=> ext_req && $stable(ext_addr) && $stable(ext_we))
    else $error("external request dropped or changed before ack");

  p_wr_from_buf_r2: assert property (@(posedge clk) disable iff (rst)
    ext_req && ext_we |-> buf_valid && ext_addr == buf_addr)
    else $error("external write does not match buffer");

  p_rd_after_drain_r6: assert property (@(posedge clk) disable iff (rst)
    ext_req && !ext_we |-> !buf_valid)
    else $error("external read issued while write pending");
endmodule

// File: rtl/posted_wbuf_front.sv
module posted_wbuf_front
  import posted_wbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] PER_TAG = '1,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic [BW-1:0] m_be,
  output logic          m_ack,
  output logic [DW-1:0] m_rdata,
  input  logic          buf_valid,
  input  logic          seq_idle,
  output logic          cap,
  output logic          rd_cmd,
  input  logic          rd_done,
  input  logic [DW-1:0] rd_data,
  output logic          per_req,
  output logic          per_we,
  output logic [AW-1:0] per_addr,
  output logic [DW-1:0] per_wdata,
  output logic [BW-1:0] per_be,
  input  logic          per_ack,
  input  logic [DW-1:0] per_rdata
);
  fe_state_t st;
  logic      take, is_per;

  assign is_per = (m_addr[AW-1 -: TAG_W] == PER_TAG);
  assign take   = (st == FE_IDLE) && m_req && !m_ack;
  assign cap    = take && !is_per && m_we && !buf_valid;
  assign rd_cmd = take && !is_per && !m_we && !buf_valid && seq_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FE_IDLE;
      m_ack   <= 1'b0;
      m_rdata <= '0;
      per_req <= 1'b0;
      per_we  <= 1'b0;
    end else begin
      m_ack <= 1'b0;
      case (st)
        FE_IDLE: begin
          if (cap) begin
            m_ack <= 1'b1;
          end else if (rd_cmd) begin
            st <= FE_RD;
          end else if (take && is_per) begin
            per_req   <= 1'b1;
            per_we    <= m_we;
            per_addr  <= m_addr;
            per_wdata <= m_wdata;
            per_be    <= m_be;
            st        <= FE_PER;
          end
        end
        FE_PER: begin
          if (per_ack) begin
            per_req <= 1'b0;
            per_we  <= 1'b0;
            m_ack   <= 1'b1;
            m_rdata <= per_rdata;
            st      <= FE_IDLE;
          end
        end
        FE_RD: begin
          if (rd_done) begin
            m_ack   <= 1'b1;
            m_rdata <= rd_data;
            st      <= FE_IDLE;
          end
        end
        default: st <= FE_IDLE;
      endcase
    end
  end

  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    m_ack |=> !m_ack)
    else $error("master ack longer than one cycle");

  p_per_hold_r5: assert property (@(posedge clk) disable iff (rst)
    per_req && !per_ack |=> per_req && $stable(per_addr))
    else $error("peripheral request dropped before ack");

  p_rd_ack_after_data_r7: assert property (@(posedge clk) disable iff (rst)
    st == FE_RD && !rd_done |=> !m_ack)
    else $error("read acknowledged without data");
endmodule

// File: rtl/posted_wbuf.sv
module posted_wbuf #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] PER_TAG = '1,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic [BW-1:0] m_be,
  output logic          m_ack,
  output logic [DW-1:0] m_rdata,
  output logic          wb_busy,
  output logic          ext_req,
  output logic          ext_we,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  output logic [BW-1:0] ext_be,
  input  logic          ext_ack,
  input  logic [DW-1:0] ext_rdata,
  output logic          per_req,
  output logic          per_we,
  output logic [AW-1:0] per_addr,
  output logic [DW-1:0] per_wdata,
  output logic [BW-1:0] per_be,
  input  logic          per_ack,
  input  logic [DW-1:0] per_rdata
);
  logic          cap, clr, buf_valid, rd_cmd, rd_done, seq_idle;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_data, rd_data;
  logic [BW-1:0] buf_be;

  assign wb_busy = buf_valid;

  posted_wbuf_front #(.AW(AW), .DW(DW), .TAG_W(TAG_W), .PER_TAG(PER_TAG)) u_front (
    .clk(clk), .rst(rst),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
    .m_ack(m_ack), .m_rdata(m_rdata),
    .buf_valid(buf_valid), .seq_idle(seq_idle), .cap(cap), .rd_cmd(rd_cmd),
    .rd_done(rd_done), .rd_data(rd_data),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_be(per_be), .per_ack(per_ack), .per_rdata(per_rdata)
  );

  posted_wbuf_entry #(.AW(AW), .DW(DW)) u_entry (
    .clk(clk), .rst(rst),
    .cap(cap), .cap_addr(m_addr), .cap_data(m_wdata), .cap_be(m_be),
    .clr(clr), .valid(buf_valid),
    .buf_addr(buf_addr), .buf_data(buf_data), .buf_be(buf_be)
  );

  posted_wbuf_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_data(buf_data), .buf_be(buf_be),
    .wr_done(clr),
    .rd_cmd(rd_cmd), .rd_addr(m_addr), .rd_done(rd_done), .rd_data(rd_data),
    .seq_idle(seq_idle),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_be(ext_be), .ext_ack(ext_ack), .ext_rdata(ext_rdata)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> !m_ack && !wb_busy && !ext_req && !per_req)
    else $error("outputs not cleared by reset");

  p_port_excl_r9: assert property (@(posedge clk) disable iff (rst)
    per_req |-> !(ext_req && !ext_we))
    else $error("read on both ports at once");

  p_per_tag_r9: assert property (@(posedge clk) disable iff (rst)
    per_req |-> per_addr[AW-1 -: TAG_W] == PER_TAG)
    else $error("non-peripheral address on peripheral port");
endmodule

// File: tb/posted_wbuf_tb_top.sv
module posted_wbuf_tb_top;
  localparam int EXT_LAT = 4;
  localparam int PER_LAT = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_req = 1'b0, m_we = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic [3:0]  m_be = '0;
  logic        m_ack, wb_busy;
  logic [31:0] m_rdata;
  logic        ext_req, ext_we, ext_ack = 1'b0;
  logic [31:0] ext_addr, ext_wdata, ext_rdata = '0;
  logic [3:0]  ext_be;
  logic        per_req, per_we, per_ack = 1'b0;
  logic [31:0] per_addr, per_wdata, per_rdata = '0;
  logic [3:0]  per_be;

  int checks = 0, fails = 0;
  int ext_wr_cnt = 0, ext_rd_cnt = 0, per_cnt = 0, ext_cyc = 0, per_cyc = 0;
  logic [31:0] ext_mem [16];
  logic [31:0] per_mem [16];
  logic        hold_ack;

  always #4 clk = ~clk;

  posted_wbuf dut_i (
    .clk(clk), .rst(rst),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
    .m_ack(m_ack), .m_rdata(m_rdata), .wb_busy(wb_busy),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_be(ext_be), .ext_ack(ext_ack), .ext_rdata(ext_rdata),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_be(per_be), .per_ack(per_ack), .per_rdata(per_rdata)
  );

  initial begin
    for (int i = 0; i < 16; i++) begin
      ext_mem[i] = 32'hA000_0000 + i;
      per_mem[i] = 32'h5000_0000 + i;
    end
  end

  // external memory model
  always @(posedge clk) begin
    if (rst) begin
      ext_ack <= 1'b0; ext_cyc <= 0;
    end else if (ext_ack) begin
      ext_ack <= 1'b0; ext_cyc <= 0;
    end else if (ext_req) begin
      if (ext_cyc == EXT_LAT) begin
        ext_ack <= 1'b1;
        if (ext_we) begin
          for (int b = 0; b < 4; b++)
            if (ext_be[b]) ext_mem[ext_addr[5:2]][b*8 +: 8] <= ext_wdata[b*8 +: 8];
          ext_wr_cnt <= ext_wr_cnt + 1;
        end else begin
          ext_rdata  <= ext_mem[ext_addr[5:2]];
          ext_rd_cnt <= ext_rd_cnt + 1;
        end
      end else ext_cyc <= ext_cyc + 1;
    end
  end

  // peripheral model
  always @(posedge clk) begin
    if (rst) begin
      per_ack <= 1'b0; per_cyc <= 0;
    end else if (per_ack) begin
      per_ack <= 1'b0; per_cyc <= 0;
    end else if (per_req) begin
      if (per_cyc == PER_LAT) begin
        per_ack <= 1'b1;
        per_cnt <= per_cnt + 1;
        if (per_we) begin
          for (int b = 0; b < 4; b++)
            if (per_be[b]) per_mem[per_addr[5:2]][b*8 +: 8] <= per_wdata[b*8 +: 8];
        end else per_rdata <= per_mem[per_addr[5:2]];
      end else per_cyc <= per_cyc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input bit hold,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    m_req = 1'b1; m_we = we; m_addr = a; m_wdata = d; m_be = be;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (!we && ext_req && !ext_we && wb_busy)
        chk(1'b0, "R6 read issued while busy", 32'd1, 32'd0);
    end while (!m_ack && cyc < 200);
    rd = m_rdata;
    hold_ack = 1'b0;
    if (hold) begin
      @(negedge clk);
      hold_ack = m_ack;
    end
    m_req = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (wb_busy && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!m_ack && !wb_busy && !ext_req && !per_req, "R1 reset state",
        {m_ack, wb_busy, ext_req, per_req}, 32'd0);
  endtask

  task automatic t_post_write();
    logic [31:0] rd; int cyc, base, n;
    base = ext_wr_cnt;
    access(1'b1, 32'h0000_0010, 32'hCAFE_0001, 4'hF, 1'b0, rd, cyc);
    chk(cyc == 1, "R2 posted write ack latency", cyc, 1);
    chk(wb_busy == 1'b1, "R2 busy with ack", wb_busy, 1);
    chk(ext_wr_cnt == base, "R2 ack before external completion", ext_wr_cnt, base);
    n = 0;
    while (wb_busy && n < 200) begin
      @(negedge clk); n++;
      if (wb_busy && ext_wr_cnt != base && ext_ack == 1'b0)
        chk(1'b0, "R3 busy after completion", 32'd1, 32'd0);
    end
    chk(ext_wr_cnt == base + 1, "R3 busy falls after write done", ext_wr_cnt, base + 1);
    chk(n >= EXT_LAT, "R3 busy held through drain", n, EXT_LAT);
    chk(ext_mem[4] == 32'hCAFE_0001, "R2 drained data", ext_mem[4], 32'hCAFE_0001);
  endtask

  task automatic t_byte_lanes();
    logic [31:0] rd; int cyc;
    access(1'b1, 32'h0000_0014, 32'h1122_3344, 4'b0101, 1'b0, rd, cyc);
    drain();
    chk(ext_mem[5] == 32'hA022_0044, "R2 byte enables", ext_mem[5], 32'hA022_0044);
  endtask

  task automatic t_full_stall();
    logic [31:0] rd; int cyc, base;
    base = ext_wr_cnt;
    access(1'b1, 32'h0000_0020, 32'h0000_AAAA, 4'hF, 1'b0, rd, cyc);
    access(1'b1, 32'h0000_0024, 32'h0000_BBBB, 4'hF, 1'b0, rd, cyc);
    chk(cyc > 1, "R4 second write stalled", cyc, 2);
    chk(ext_wr_cnt == base + 1, "R4 first write done before second ack", ext_wr_cnt, base + 1);
    chk(wb_busy == 1'b1, "R4 second write captured", wb_busy, 1);
    drain();
    chk(ext_mem[9] == 32'h0000_BBBB, "R4 second write drained", ext_mem[9], 32'h0000_BBBB);
  endtask

  task automatic t_periph_overtake();
    logic [31:0] rd; int cyc, base, pbase;
    base = ext_wr_cnt; pbase = per_cnt;
    access(1'b1, 32'h0000_0030, 32'h0000_CCCC, 4'hF, 1'b0, rd, cyc);
    access(1'b0, 32'hF000_0008, 32'h0, 4'hF, 1'b0, rd, cyc);
    chk(rd == 32'h5000_0002, "R5 peripheral read data", rd, 32'h5000_0002);
    chk(wb_busy == 1'b1 && ext_wr_cnt == base, "R5 overtakes pending write", ext_wr_cnt, base);
    chk(cyc == PER_LAT + 3, "R5 peripheral ack timing", cyc, PER_LAT + 3);
    access(1'b1, 32'hF000_000C, 32'h0000_DDDD, 4'hF, 1'b0, rd, cyc);
    drain();
    chk(per_cnt == pbase + 2, "R9 peripheral accesses on peripheral port", per_cnt, pbase + 2);
    chk(per_mem[3] == 32'h0000_DDDD, "R9 peripheral write landed", per_mem[3], 32'h0000_DDDD);
    chk(ext_wr_cnt == base + 1 && ext_mem[12] == 32'h0000_CCCC, "R9 external write only once",
        ext_wr_cnt, base + 1);
  endtask

  task automatic t_read_after_write();
    logic [31:0] rd; int cyc, wbase, rbase;
    wbase = ext_wr_cnt; rbase = ext_rd_cnt;
    access(1'b1, 32'h0000_0038, 32'h0BAD_F00D, 4'hF, 1'b0, rd, cyc);
    access(1'b0, 32'h0000_0038, 32'h0, 4'hF, 1'b0, rd, cyc);
    chk(rd == 32'h0BAD_F00D, "R6 dummy read sees written data", rd, 32'h0BAD_F00D);
    chk(ext_wr_cnt == wbase + 1, "R6 write completed before read ack", ext_wr_cnt, wbase + 1);
    chk(ext_rd_cnt == rbase + 1, "R7 read acked after target ack", ext_rd_cnt, rbase + 1);
    access(1'b0, 32'h0000_003C, 32'h0, 4'hF, 1'b0, rd, cyc);
    chk(rd == 32'hA000_000F, "R7 plain external read data", rd, 32'hA000_000F);
  endtask

  task automatic t_ack_once();
    logic [31:0] rd; int cyc, base;
    drain();
    base = ext_wr_cnt;
    access(1'b1, 32'h0000_0000, 32'h0000_1234, 4'hF, 1'b1, rd, cyc);
    chk(hold_ack == 1'b0, "R8 ack is single pulse", hold_ack, 0);
    drain();
    repeat (EXT_LAT + 4) @(negedge clk);
    chk(ext_wr_cnt == base + 1, "R8 held request accepted once", ext_wr_cnt, base + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_post_write();
    t_byte_lanes();
    t_full_stall();
    t_periph_overtake();
    t_read_after_write();
    t_ack_once();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule